// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer

This block is the digital half of a 10-bit successive-approximation converter in a small 4-bit microcontroller. A 4-bit control word, written from the accumulator and readable back, chooses between conversion mode and comparator mode and names one of six analog inputs. The block drives a one-hot enable for the analog input multiplexer and a 10-bit trial code for the DAC. It samples one comparator bit that is high when the input lies above the DAC voltage.

A start strobe in conversion mode clears the result register and launches a fixed 62-machine-cycle conversion, paced by a machine-cycle enable. The sequence has one setup cycle, then six cycles per bit from the most significant bit down, then one closing cycle. At the end the block raises a completion flag. The flag either requests an interrupt or waits to be polled, depending on an interrupt-enable input, and it is cleared by interrupt acceptance or by a poll that skips. The result is read out as an 8-bit high part and a 2-bit low part. The low part sits in the upper half of a 4-bit word.

Top module: `sar_adc_ctrl`

## Requirements
- R1: The control word resets to 0000; a write loads all four bits and `ctl_rdata` returns them on the following cycle.
- R2: Control bits 2:0 with value k in 0..5 drive `ch_sel` one-hot with only bit k set; values 6 and 7 drive `ch_sel` to all zeros.
- R3: With control bit 3 = 1 (comparator mode), `start` launches nothing: `busy` stays 0, and the result and the flag keep their values.
- R4: A `start` in conversion mode (bit 3 = 0) makes `dac_code` 0 on the next cycle. The first enabled machine cycle after it then sets `dac_code` to 0x200.
- R5: Each bit trial keeps the bit when `cmp_hi` = 1 and clears it when `cmp_hi` = 0. The final code is the largest n (0..1023) whose DAC level lies below the input, or 0 when no level does.
- R6: `busy` rises with the start and falls on exactly the 62nd enabled machine cycle after it. The completion flag is set on that same edge.
- R7: While `ce` is low, a running conversion does not advance: `dac_code` and `busy` hold.
- R8: With `int_en` = 1, `irq_req` equals the flag, and `irq_ack` clears the flag. With `int_en` = 0, `irq_req` is 0 and `irq_ack` has no effect.
- R9: With `int_en` = 0, `poll_req` while the flag is set drives `poll_skip` high in that cycle and clears the flag. A poll with the flag clear gives no skip.
- R10: `rd_hi` returns result bits 9:2, and `rd_lo` returns result bits 1:0 in its bits 3:2 with zeros below. The result holds unchanged after completion.
- R11: A `start` during a conversion restarts it from a cleared register and runs a full 62 enabled cycles from the new start.
- R12: If completion and a flag clear fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word from accumulator |
| ctl_rdata | output | 4 | Control word read-back |
| start | input | 1 | Conversion start strobe |
| ce | input | 1 | Machine-cycle enable |
| cmp_hi | input | 1 | Comparator: input above DAC level |
| dac_code | output | 10 | Trial code to DAC (result register) |
| ch_sel | output | 6 | One-hot analog input enable |
| busy | output | 1 | Conversion in progress |
| int_en | input | 1 | 1 = interrupt path, 0 = polling path |
| irq_ack | input | 1 | Interrupt accepted |
| poll_req | input | 1 | Poll instruction tests flag |
| done_flag | output | 1 | Completion flag |
| irq_req | output | 1 | Interrupt request |
| poll_skip | output | 1 | Poll result: skip next instruction |
| rd_hi | output | 8 | Result bits 9:2 |
| rd_lo | output | 4 | Result bits 1:0 in bits 3:2 |

## Verification
The bench builds the block with its default parameters: 10 result bits, a 62-cycle conversion (six cycles per bit), six channels, a 3-bit channel field and restart-on-start enabled. With these values both reserved channel codes and the code extremes 0 and 1023 can be reached. The input model can also sit on exact DAC levels, so the boundary between keeping and clearing a bit is exercised. The 62-cycle window is short enough that the bench can count every enabled cycle and probe the 61st and 62nd edges directly. It also covers stalls with `ce` held low, a mid-conversion restart, and a completion that meets an interrupt acknowledge in the same cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_RUN    = 2'd2,
      PH_FINISH = 2'd3
   } sar_phase_e;

   typedef enum logic {
      MODE_CONVERT = 1'b0,
      MODE_COMPARE = 1'b1
   } sar_mode_e;
endpackage

// File: rtl/sar_ctl_reg.sv
module sar_ctl_reg #(
   parameter int SEL_W      = 3,
   parameter int CHAN_COUNT = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [SEL_W:0]        wdata,
   output logic [SEL_W:0]        rdata,
   output logic                  mode_cmp,
   output logic [CHAN_COUNT-1:0] ch_sel
);
   logic [SEL_W:0]   ctl_q;
   logic [SEL_W-1:0] sel;

   always_ff @(posedge clk) begin
      if (!rst_n)  ctl_q <= '0;
      else if (we) ctl_q <= wdata;
   end

   assign sel      = ctl_q[SEL_W-1:0];
   assign mode_cmp = (ctl_q[SEL_W] == sar_pkg::MODE_COMPARE);
   assign rdata    = ctl_q;

   for (genvar g = 0; g < CHAN_COUNT; g++) begin : g_dec
      assign ch_sel[g] = (sel == SEL_W'(g));
   end

   a_r1_write: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> rdata == $past(wdata));
   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_sel));
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
   parameter int RES_BITS    = 10,
   parameter int SLOT_CYCLES = 6,
   localparam int IDX_W = $clog2(RES_BITS),
   localparam int SUB_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             ce,
   output logic             busy,
   output logic             setup_stb,
   output logic             sample_stb,
   output logic             done_stb,
   output logic [IDX_W-1:0] bit_idx
);
   import sar_pkg::*;

   sar_phase_e       phase;
   logic [SUB_W-1:0] sub;
   logic             slot_end;
   logic             step;

   assign slot_end = (sub == SUB_W'(SLOT_CYCLES - 1));
   assign step     = ce && !launch;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         sub     <= '0;
         bit_idx <= '0;
      end else if (launch) begin
         phase   <= PH_SETUP;
         sub     <= '0;
         bit_idx <= IDX_W'(RES_BITS - 1);
      end else if (ce) begin
         case (phase)
            PH_SETUP: begin
               phase   <= PH_RUN;
               sub     <= '0;
               bit_idx <= IDX_W'(RES_BITS - 1);
            end
            PH_RUN: begin
               if (slot_end) begin
                  sub <= '0;
                  if (bit_idx == '0) phase <= PH_FINISH;
                  else               bit_idx <= bit_idx - IDX_W'(1);
               end else begin
                  sub <= sub + SUB_W'(1);
               end
            end
            PH_FINISH: phase <= PH_IDLE;
            default:   phase <= PH_IDLE;
         endcase
      end
   end

   assign busy       = (phase != PH_IDLE);
   assign setup_stb  = step && (phase == PH_SETUP);
   assign sample_stb = step && (phase == PH_RUN) && slot_end;
   assign done_stb   = step && (phase == PH_FINISH);

   a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ce && !launch) |=> busy && $stable(bit_idx) && $stable(sub));
endmodule

// File: rtl/sar_code_reg.sv
module sar_code_reg #(
   parameter int RES_BITS = 10,
   localparam int IDX_W   = $clog2(RES_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                launch,
   input  logic                setup_stb,
   input  logic                sample_stb,
   input  logic [IDX_W-1:0]    bit_idx,
   input  logic                cmp_hi,
   output logic [RES_BITS-1:0] code
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code <= '0;
      end else if (launch) begin
         code <= '0;
      end else if (setup_stb) begin
         code[RES_BITS-1] <= 1'b1;
      end else if (sample_stb) begin
         if (!cmp_hi) code[bit_idx] <= 1'b0;
         if (bit_idx != '0) code[bit_idx - IDX_W'(1)] <= 1'b1;
      end
   end

   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> code == '0);
   a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && cmp_hi) |=> code[$past(bit_idx)]);
   a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_stb && !cmp_hi) |=> !code[$past(bit_idx)]);
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch && !setup_stb && !sample_stb) |=> $stable(code));
endmodule

// File: rtl/sar_flag.sv
module sar_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic done_stb,
   input  logic int_en,
   input  logic irq_ack,
   input  logic poll_req,
   output logic flag,
   output logic irq_req,
   output logic poll_skip
);
   logic clr;

   assign clr = (int_en && irq_ack) || (!int_en && poll_req);

   always_ff @(posedge clk) begin
      if (!rst_n)        flag <= 1'b0;
      else if (done_stb) flag <= 1'b1;
      else if (clr)      flag <= 1'b0;
   end

   assign irq_req   = flag && int_en;
   assign poll_skip = flag && !int_en && poll_req;

   a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      done_stb |=> flag);
   a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en && irq_ack && !done_stb) |=> !flag);
   a_r9_poll_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_en && poll_req && !done_stb) |=> !flag);
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
   parameter int RES_BITS         = 10,
   parameter int CONV_CYCLES      = 62,
   parameter int CHAN_COUNT       = 6,
   parameter int SEL_W            = 3,
   parameter bit RESTART_ON_START = 1'b1,
   localparam int SLOT_CYCLES = (CONV_CYCLES - 2) / RES_BITS,
   localparam int IDX_W       = $clog2(RES_BITS),
   localparam int CNT_W       = $clog2(CONV_CYCLES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ctl_we,
   input  logic [SEL_W:0]        ctl_wdata,
   output logic [SEL_W:0]        ctl_rdata,
   input  logic                  start,
   input  logic                  ce,
   input  logic                  cmp_hi,
   output logic [RES_BITS-1:0]   dac_code,
   output logic [CHAN_COUNT-1:0] ch_sel,
   output logic                  busy,
   input  logic                  int_en,
   input  logic                  irq_ack,
   input  logic                  poll_req,
   output logic                  done_flag,
   output logic                  irq_req,
   output logic                  poll_skip,
   output logic [RES_BITS-3:0]   rd_hi,
   output logic [3:0]            rd_lo
);
   if ((CONV_CYCLES - 2) % RES_BITS != 0 || SLOT_CYCLES < 1) begin : g_bad_cycles
      $error("CONV_CYCLES-2 must be a positive multiple of RES_BITS");
   end
   if (RES_BITS < 3) begin : g_bad_res
      $error("RES_BITS must be at least 3");
   end
   if (CHAN_COUNT > (1 << SEL_W) || CHAN_COUNT < 1) begin : g_bad_chan
      $error("CHAN_COUNT must fit the channel field");
   end

   logic             mode_cmp;
   logic             launch;
   logic             setup_stb, sample_stb, done_stb;
   logic [IDX_W-1:0] bit_idx;

   sar_ctl_reg #(.SEL_W(SEL_W), .CHAN_COUNT(CHAN_COUNT)) u_ctl (
      .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
      .rdata(ctl_rdata), .mode_cmp(mode_cmp), .ch_sel(ch_sel)
   );

   if (RESTART_ON_START) begin : g_restart
      assign launch = start && !mode_cmp;
   end else begin : g_no_restart
      assign launch = start && !mode_cmp && !busy;
   end

   sar_seq #(.RES_BITS(RES_BITS), .SLOT_CYCLES(SLOT_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .launch(launch), .ce(ce), .busy(busy),
      .setup_stb(setup_stb), .sample_stb(sample_stb), .done_stb(done_stb),
      .bit_idx(bit_idx)
   );

   sar_code_reg #(.RES_BITS(RES_BITS)) u_code (
      .clk(clk), .rst_n(rst_n), .launch(launch), .setup_stb(setup_stb),
      .sample_stb(sample_stb), .bit_idx(bit_idx), .cmp_hi(cmp_hi),
      .code(dac_code)
   );

   sar_flag u_flag (
      .clk(clk), .rst_n(rst_n), .done_stb(done_stb), .int_en(int_en),
      .irq_ack(irq_ack), .poll_req(poll_req), .flag(done_flag),
      .irq_req(irq_req), .poll_skip(poll_skip)
   );

   assign rd_hi = dac_code[RES_BITS-1:2];
   assign rd_lo = {dac_code[1:0], 2'b00};

   // Checker: enabled cycles seen since the last launch.
   logic [CNT_W-1:0] ce_seen;
   always_ff @(posedge clk) begin
      if (!rst_n || launch)            ce_seen <= '0;
      else if (busy && ce && ce_seen != CNT_W'(CONV_CYCLES))
                                       ce_seen <= ce_seen + CNT_W'(1);
   end

   a_r6_duration: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ce_seen == CNT_W'(CONV_CYCLES));
   a_r6_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_flag);
   a_r3_compare_ignores: assert property (@(posedge clk) disable iff (!rst_n)
      (start && mode_cmp && !busy) |=> !busy);
endmodule

// File: tb/sar_adc_ctrl_tb_top.sv
module sar_adc_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [3:0]  ctl_wdata = '0;
   logic [3:0]  ctl_rdata;
   logic        start = 1'b0;
   logic        ce = 1'b0;
   logic        cmp_hi;
   logic [9:0]  dac_code;
   logic [5:0]  ch_sel;
   logic        busy;
   logic        int_en = 1'b1;
   logic        irq_ack = 1'b0;
   logic        poll_req = 1'b0;
   logic        done_flag, irq_req, poll_skip;
   logic [7:0]  rd_hi;
   logic [3:0]  rd_lo;
   logic [10:0] vin = '0;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   // Comparator model: high when the input lies above the DAC level.
   assign cmp_hi = ({1'b0, dac_code} < vin);

   sar_adc_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .start(start), .ce(ce), .cmp_hi(cmp_hi),
      .dac_code(dac_code), .ch_sel(ch_sel), .busy(busy), .int_en(int_en),
      .irq_ack(irq_ack), .poll_req(poll_req), .done_flag(done_flag),
      .irq_req(irq_req), .poll_skip(poll_skip), .rd_hi(rd_hi), .rd_lo(rd_lo)
   );

   typedef struct packed {
      logic [2:0]  ch;
      logic [10:0] vin;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{3'd0, 11'd0},    '{3'd1, 11'd1},    '{3'd2, 11'd512},  '{3'd3, 11'd513},
      '{3'd4, 11'd1023}, '{3'd5, 11'd1024}, '{3'd6, 11'd700},  '{3'd7, 11'd341}
   };

   function automatic logic [9:0] exp_code(input logic [10:0] v);
      if (v == 0)         return 10'd0;
      else if (v > 11'd1023) return 10'd1023;
      else                return 10'(v - 11'd1);
   endfunction

   function automatic logic [5:0] exp_sel(input logic [2:0] c);
      return (c < 3'd6) ? 6'(1 << c) : 6'd0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_ctl(input logic [3:0] v);
      @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_we = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic ce_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ce = 1'b1;
         @(negedge clk); ce = 1'b0;
      end
   endtask

   task automatic ack_irq();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [9:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Reset state
      chk("R1 reset ctl", 32'(ctl_rdata), 32'h0);
      chk("R2 reset sel", 32'(ch_sel), 32'h1);
      chk("R6 reset busy", 32'(busy), 32'h0);
      chk("R10 reset code", 32'(dac_code), 32'h0);
      chk("R8 reset flag", 32'(done_flag), 32'h0);

      // Vector table walk
      for (int k = 0; k < 8; k++) begin
         vin = VECS[k].vin;
         int_en = 1'b1;
         write_ctl({1'b0, VECS[k].ch});
         chk("R1 readback", 32'(ctl_rdata), 32'({1'b0, VECS[k].ch}));
         chk("R2 channel", 32'(ch_sel), 32'(exp_sel(VECS[k].ch)));
         pulse_start();
         chk("R4 cleared", 32'(dac_code), 32'h0);
         chk("R6 busy up", 32'(busy), 32'h1);
         ce_pulses(1);
         chk("R4 msb trial", 32'(dac_code), 32'h200);
         ce_pulses(60);
         chk("R6 busy at 61", 32'(busy), 32'h1);
         chk("R6 flag at 61", 32'(done_flag), 32'h0);
         ce_pulses(1);
         chk("R6 busy at 62", 32'(busy), 32'h0);
         chk("R6 flag at 62", 32'(done_flag), 32'h1);
         chk("R5 result", 32'(dac_code), 32'(exp_code(vin)));
         chk("R10 rd_hi", 32'(rd_hi), 32'(exp_code(vin) >> 2));
         chk("R10 rd_lo", 32'(rd_lo), 32'({exp_code(vin)[1:0], 2'b00}));
         chk("R8 irq_req", 32'(irq_req), 32'h1);
         ce_pulses(3);
         chk("R10 hold", 32'(dac_code), 32'(exp_code(vin)));
         ack_irq();
         chk("R8 ack clears", 32'(done_flag), 32'h0);
      end

      // R7 stall and R11 restart
      write_ctl(4'b0000);
      vin = 11'd900;
      pulse_start();
      ce_pulses(3);
      chk("R7 pre-stall", 32'(dac_code), 32'h200);
      repeat (10) @(negedge clk);
      chk("R7 stall code", 32'(dac_code), 32'h200);
      chk("R7 stall busy", 32'(busy), 32'h1);
      ce_pulses(17);
      vin = 11'd300;
      pulse_start();
      chk("R11 restart clear", 32'(dac_code), 32'h0);
      chk("R11 restart busy", 32'(busy), 32'h1);
      ce_pulses(61);
      chk("R11 busy at 61", 32'(busy), 32'h1);
      ce_pulses(1);
      chk("R11 busy at 62", 32'(busy), 32'h0);
      chk("R11 result", 32'(dac_code), 32'(exp_code(vin)));

      // R8/R9 polling path
      int_en = 1'b0;
      @(negedge clk);
      chk("R8 irq masked", 32'(irq_req), 32'h0);
      ack_irq();
      chk("R8 ack ignored", 32'(done_flag), 32'h1);
      @(negedge clk); poll_req = 1'b1;
      #1;
      chk("R9 skip", 32'(poll_skip), 32'h1);
      @(negedge clk); poll_req = 1'b0;
      chk("R9 poll clears", 32'(done_flag), 32'h0);
      @(negedge clk); poll_req = 1'b1;
      #1;
      chk("R9 no skip", 32'(poll_skip), 32'h0);
      @(negedge clk); poll_req = 1'b0;

      // R3 comparator mode
      int_en = 1'b1;
      held = dac_code;
      write_ctl(4'b1010);
      chk("R1 readback cmp", 32'(ctl_rdata), 32'hA);
      chk("R2 channel cmp", 32'(ch_sel), 32'h4);
      vin = 11'd5;
      pulse_start();
      chk("R3 no busy", 32'(busy), 32'h0);
      ce_pulses(70);
      chk("R3 busy idle", 32'(busy), 32'h0);
      chk("R3 code kept", 32'(dac_code), 32'(held));
      chk("R3 flag kept", 32'(done_flag), 32'h0);
      chk("R10 rd_lo kept", 32'(rd_lo), 32'({held[1:0], 2'b00}));

      // R12 completion meets acknowledge
      write_ctl(4'b0001);
      vin = 11'd777;
      pulse_start();
      ce_pulses(61);
      @(negedge clk); ce = 1'b1; irq_ack = 1'b1;
      @(negedge clk); ce = 1'b0; irq_ack = 1'b0;
      chk("R12 set wins", 32'(done_flag), 32'h1);
      chk("R5 result 777", 32'(dac_code), 32'd776);
      ack_irq();
      chk("R12 later clear", 32'(done_flag), 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule